// File: doc/BRIEF.md
# Serial Register-Access Target with Persistent Pointer

This block lets a two-wire serial bus controller read and write a bank of up to 1024 byte-wide registers. It is always a bus target and never drives the clock. It answers to one fixed 7-bit device address. In a write, two index bytes follow the device byte. The first index byte carries an auto-increment flag in its top bit and the upper bits of the register index. The second index byte carries the low eight bits of the index. Any data bytes that follow the index bytes go to the register at the pointer.

The pointer persists from one transaction to the next. A read that starts directly with the read bit set returns the byte at the pointer as it stands. A random read loads the pointer with a write phase that carries only the two index bytes, then issues a repeated START with the read bit set. After each byte is transferred, the pointer advances if auto-increment is set and stays put if it is clear.

A register can report that it is not available. The target then leaves SDA released in the acknowledge slot. SCL and SDA are sampled by the system clock through a synchronizer. The open-drain data line is controlled by a single enable output.

Top module: `i2c_reg_target`

## Requirements
- R1: While reset is low and in the first cycle after it is released, `sda_oe` is 0 and neither `reg_we` nor `reg_re` is asserted.
- R2: The target acknowledges (pulls SDA low in the 9th clock) a first byte whose upper seven bits equal 7'b1101010. Device byte 8'hD4 means write and 8'hD5 means read. Any other device address is not acknowledged, and SDA stays released with no register access until the next START, even if further bytes follow.
- R3: In a write, both index bytes are acknowledged. Bit 7 of the first index byte is the auto-increment flag. Bits 1:0 of the first index byte are index bits 9:8. The second index byte is index bits 7:0.
- R4: Each data byte of a write goes to the register at the pointer as a single-cycle `reg_we` pulse and is acknowledged. With auto-increment set, the pointer then advances by one.
- R5: With auto-increment clear, every data byte of a write, and every byte of a read, uses the same register.
- R6: After a write phase that carries only the index bytes, a repeated START with the read bit set returns the register at the loaded index, MSB first. A controller ACK makes the target send the next byte.
- R7: A read started directly with the read bit set uses the pointer left by the previous transaction.
- R8: If `reg_avail` is low for the register at the pointer, a write data byte is neither written nor acknowledged, and a read device byte is not acknowledged.
- R9: A START seen in the middle of a byte abandons that byte, and the following transaction runs normally.
- R10: After the controller NACKs a read byte, the target keeps SDA released.
- R11: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock as seen on the pin |
| sda_i | input | 1 | Bus data as seen on the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| reg_addr | output | 10 | Register index (the pointer) |
| reg_wdata | output | 8 | Byte to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 8 | Byte at `reg_addr`, combinational |
| reg_re | output | 1 | One-cycle read strobe |
| reg_avail | input | 1 | Register at `reg_addr` can be accessed |

## Verification
The bench drives write bursts with auto-increment set and then with it clear. A later read of neighbouring registers shows whether the increment flag was decoded or ignored. A random read through a dummy write is contrasted with a current-address read that follows it, which separates loading the pointer from simply keeping it. An index whose upper bits are non-zero checks where the index bits are placed. An unavailable register, a foreign device address and a START cut into the middle of a byte each test that the acknowledge is withheld, or that the target recovers, without any register being touched.

// File: rtl/i2c_tgt_pkg.sv
// Shared types for the serial register target.
// Assumes nothing beyond IEEE 1800-2017.
package i2c_tgt_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,    // bus released, waiting for START
        ST_DEV,     // receiving device byte
        ST_IDX_HI,  // receiving upper index byte
        ST_IDX_LO,  // receiving lower index byte
        ST_WDATA,   // receiving write data
        ST_RDATA    // transmitting read data
    } tgt_state_t;

    localparam int BYTE_BITS = 8;
endpackage

// File: rtl/i2c_tgt_sync.sv
// Brings SCL and SDA into the system clock domain and flags SCL edges
// and START/STOP conditions. Assumes the system clock runs at least
// several times faster than SCL; idle bus level is high.
module i2c_tgt_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic sda_s,
    output logic start_det,
    output logic stop_det
);
    logic [SYNC_STAGES-1:0] scl_pipe, sda_pipe;
    logic scl_prev, sda_prev, scl_s;

    // Synchronizer chains, one stage per flop
    genvar g;
    generate
        for (g = 0; g < SYNC_STAGES; g++) begin : g_stage
            // Shift one stage of each chain
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    scl_pipe[g] <= 1'b1;
                    sda_pipe[g] <= 1'b1;
                end else if (g == 0) begin
                    scl_pipe[g] <= scl_i;
                    sda_pipe[g] <= sda_i;
                end else begin
                    scl_pipe[g] <= scl_pipe[g-1];
                    sda_pipe[g] <= sda_pipe[g-1];
                end
            end
        end
    endgenerate

    assign scl_s = scl_pipe[SYNC_STAGES-1];
    assign sda_s = sda_pipe[SYNC_STAGES-1];

    // Previous synchronized values for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_prev <= scl_s;
            sda_prev <= sda_s;
        end
    end

    assign scl_rise  = scl_s & ~scl_prev;
    assign scl_fall  = ~scl_s & scl_prev;
    assign start_det = scl_s & scl_prev & sda_prev & ~sda_s;
    assign stop_det  = scl_s & scl_prev & ~sda_prev & sda_s;
endmodule

// File: rtl/i2c_tgt_fsm.sv
// Byte-level protocol engine: device match, index capture, write and
// read data, acknowledge handling and the persistent register pointer.
// Assumes synchronized inputs and single-cycle edge/condition pulses;
// reg_rdata and reg_avail are combinational functions of reg_addr.
module i2c_tgt_fsm
    import i2c_tgt_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h6A,
    parameter int         IDX_W    = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_s,
    input  logic             start_det,
    input  logic             stop_det,
    output logic             sda_oe,
    output logic [IDX_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata,
    output logic             reg_re,
    input  logic             reg_avail
);
    localparam int HI_BITS = IDX_W - BYTE_BITS;
    localparam int CNT_W   = $clog2(BYTE_BITS + 1);
    localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_BITS);

    tgt_state_t        st;
    logic [CNT_W-1:0]  bitcnt;
    logic              in_ack, sda_drv, rd_mode, mack;
    logic [7:0]        shreg, txd;
    logic [IDX_W-1:0]  ptr;
    logic              inc, hi_inc;
    logic [HI_BITS-1:0] hi_bits;
    logic              rx_state, dec_fall, dev_match;

    assign rx_state  = (st == ST_DEV) || (st == ST_IDX_HI) ||
                       (st == ST_IDX_LO) || (st == ST_WDATA);
    assign dec_fall  = rx_state && scl_fall && (bitcnt == LAST_BIT) && !in_ack;
    assign dev_match = (shreg[7:1] == DEV_ADDR);

    // Register-side strobes, decided in the cycle the byte completes
    assign reg_we    = dec_fall && (st == ST_WDATA) && reg_avail;
    assign reg_re    = reg_avail &&
                       ((dec_fall && (st == ST_DEV) && dev_match && shreg[0]) ||
                        ((st == ST_RDATA) && in_ack && scl_rise && !sda_s));
    assign reg_addr  = ptr;
    assign reg_wdata = shreg;
    assign sda_oe    = sda_drv;

    // Protocol state, shift registers, pointer and SDA drive
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_drv <= 1'b0;
            rd_mode <= 1'b0; mack <= 1'b0; shreg <= '0; txd <= '0;
            ptr <= '0; inc <= 1'b0; hi_inc <= 1'b0; hi_bits <= '0;
        end else if (start_det) begin
            st <= ST_DEV; bitcnt <= '0; in_ack <= 1'b0; sda_drv <= 1'b0;
        end else if (stop_det) begin
            st <= ST_IDLE; bitcnt <= '0; in_ack <= 1'b0; sda_drv <= 1'b0;
        end else if (rx_state) begin
            if (scl_rise && bitcnt != LAST_BIT) begin
                shreg  <= {shreg[6:0], sda_s};
                bitcnt <= bitcnt + 1'b1;
            end
            if (dec_fall) begin
                in_ack <= 1'b1;
                case (st)
                    ST_DEV: begin
                        rd_mode <= shreg[0];
                        if (!dev_match) st <= ST_IDLE;
                        else if (!shreg[0]) sda_drv <= 1'b1;
                        else if (reg_avail) begin
                            sda_drv <= 1'b1;
                            txd     <= reg_rdata;
                            ptr     <= ptr + IDX_W'(inc);
                        end else st <= ST_IDLE;
                    end
                    ST_IDX_HI: begin
                        sda_drv <= 1'b1;
                        hi_inc  <= shreg[7];
                        hi_bits <= shreg[HI_BITS-1:0];
                    end
                    ST_IDX_LO: begin
                        sda_drv <= 1'b1;
                        ptr     <= {hi_bits, shreg};
                        inc     <= hi_inc;
                    end
                    default: begin
                        if (reg_avail) begin
                            sda_drv <= 1'b1;
                            ptr     <= ptr + IDX_W'(inc);
                        end
                    end
                endcase
            end else if (scl_fall && in_ack) begin
                in_ack  <= 1'b0;
                bitcnt  <= '0;
                sda_drv <= 1'b0;
                case (st)
                    ST_DEV: begin
                        if (rd_mode) begin
                            st      <= ST_RDATA;
                            sda_drv <= ~txd[7];
                        end else st <= ST_IDX_HI;
                    end
                    ST_IDX_HI: st <= ST_IDX_LO;
                    default:   st <= ST_WDATA;
                endcase
            end
        end else if (st == ST_RDATA) begin
            if (!in_ack) begin
                if (scl_rise && bitcnt != LAST_BIT) bitcnt <= bitcnt + 1'b1;
                if (scl_fall) begin
                    if (bitcnt == LAST_BIT) begin
                        sda_drv <= 1'b0;
                        in_ack  <= 1'b1;
                    end else begin
                        txd     <= {txd[6:0], 1'b0};
                        sda_drv <= ~txd[6];
                    end
                end
            end else begin
                if (scl_rise) begin
                    mack <= !sda_s && reg_avail;
                    if (!sda_s && reg_avail) begin
                        txd <= reg_rdata;
                        ptr <= ptr + IDX_W'(inc);
                    end
                end
                if (scl_fall) begin
                    in_ack <= 1'b0;
                    bitcnt <= '0;
                    if (mack) sda_drv <= ~txd[7];
                    else      st      <= ST_IDLE;
                end
            end
        end
    end
endmodule

// File: rtl/i2c_reg_target.sv
// Top of the serial register target: synchronizer plus protocol engine.
// Assumes an external open-drain pad: sda_oe=1 pulls SDA low.
module i2c_reg_target #(
    parameter logic [6:0] DEV_ADDR    = 7'h6A,
    parameter int         IDX_W       = 10,
    parameter int         SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_oe,
    output logic [IDX_W-1:0] reg_addr,
    output logic [7:0]       reg_wdata,
    output logic             reg_we,
    input  logic [7:0]       reg_rdata,
    output logic             reg_re,
    input  logic             reg_avail
);
    logic scl_rise, scl_fall, sda_s, start_det, stop_det;

    i2c_tgt_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_rise(scl_rise), .scl_fall(scl_fall), .sda_s(sda_s),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_s(sda_s), .start_det(start_det), .stop_det(stop_det),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re),
        .reg_avail(reg_avail)
    );
endmodule

// File: rtl/i2c_reg_target_chk.sv
// Port-level property checker for i2c_reg_target, attached by bind.
// Assumes SCL low phases last longer than the synchronizer delay.
module i2c_reg_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic reg_we,
    input logic reg_re,
    input logic reg_avail
);
    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_we && reg_re));                              // R4
    AST_WE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);                               // R4
    AST_WE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> reg_avail);                             // R8
    AST_RE_AVAIL: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |-> reg_avail);                             // R8
    AST_SDA_LOW_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);                      // R11
endmodule

bind i2c_reg_target i2c_reg_target_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe),
    .reg_we(reg_we), .reg_re(reg_re), .reg_avail(reg_avail)
);

// File: tb/i2c_reg_target_bench.sv
module i2c_reg_target_bench;
    localparam int CLK_PERIOD = 10;
    localparam int Q = 10;

    logic clk = 0, rst_n = 0, scl = 1, sda_m = 1;
    logic sda_oe, reg_we, reg_re, reg_avail;
    logic [9:0] reg_addr;
    logic [7:0] reg_wdata, reg_rdata;
    wire  sda_line = sda_m & ~sda_oe;

    logic [7:0] regs [0:1023];
    logic [7:0] exp_mem [0:1023];
    logic [9:0] m_ptr = '0;
    logic       m_inc = 1'b0;
    int checks = 0, failures = 0, we_cnt = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    i2c_reg_target u_i2c_reg_target (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
        .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_we(reg_we), .reg_rdata(reg_rdata), .reg_re(reg_re),
        .reg_avail(reg_avail)
    );

    // Behavioural register bank: 0x3FF is never available
    assign reg_rdata = regs[reg_addr];
    assign reg_avail = (reg_addr != 10'h3FF);
    always @(posedge clk) if (reg_we) begin
        regs[reg_addr] <= reg_wdata;
        we_cnt <= we_cnt + 1;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_start();
        sda_m = 1; wt(Q); scl = 1; wt(Q); sda_m = 0; wt(Q); scl = 0; wt(Q);
    endtask

    task automatic t_stop();
        sda_m = 0; wt(Q); scl = 1; wt(Q); sda_m = 1; wt(Q);
    endtask

    task automatic send_bit(input logic b);
        wt(Q); sda_m = b; wt(Q); scl = 1; wt(2*Q); scl = 0;
    endtask

    task automatic recv_bit(output logic b);
        sda_m = 1; wt(2*Q); scl = 1; wt(Q); b = sda_line; wt(Q); scl = 0;
    endtask

    task automatic wbyte(input logic [7:0] d, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        recv_bit(b);
        ack = !b;
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] d);
        for (int i = 7; i >= 0; i--) recv_bit(d[i]);
        send_bit(!give_ack);
    endtask

    // Write phase carrying only the index; updates the pointer model
    task automatic set_idx(input logic [9:0] idx, input logic inc);
        logic a;
        t_start();
        wbyte(8'hD4, a); chk(a, "R2 write device ack", a, 1);
        wbyte({inc, 5'b0, idx[9:8]}, a); chk(a, "R3 upper index ack", a, 1);
        wbyte(idx[7:0], a); chk(a, "R3 lower index ack", a, 1);
        m_ptr = idx; m_inc = inc;
    endtask

    task automatic wr_data(input logic [7:0] d);
        logic a, e;
        e = (m_ptr != 10'h3FF);
        wbyte(d, a);
        chk(a == e, "R4 R8 data ack", a, e);
        if (e) begin exp_mem[m_ptr] = d; m_ptr = m_ptr + 10'(m_inc); end
    endtask

    task automatic rd_begin();
        logic a, e;
        e = (m_ptr != 10'h3FF);
        t_start();
        wbyte(8'hD5, a); chk(a == e, "R7 R8 read device ack", a, e);
    endtask

    task automatic rd_data(input logic give_ack, input string tag);
        logic [7:0] d;
        rbyte(give_ack, d);
        chk(d == exp_mem[m_ptr], tag, d, exp_mem[m_ptr]);
        m_ptr = m_ptr + 10'(m_inc);
        if (!give_ack) begin
            wt(Q);
            chk(sda_oe == 0, "R10 released after NACK", sda_oe, 0);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) begin
            regs[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
    end

    initial begin
        logic a;
        int base;
        wt(5);
        chk(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R1 reset quiet", sda_oe, 0);
        rst_n = 1; wt(1);
        chk(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R1 after reset", sda_oe, 0);
        wt(20);

        // R4: auto-increment burst
        set_idx(10'h010, 1);
        wr_data(8'hA1); wr_data(8'hB2); wr_data(8'hC3); wr_data(8'hD4);
        t_stop(); wt(20);
        chk(regs[10'h013] == 8'hD4, "R4 last burst byte", regs[10'h013], 8'hD4);

        // R6: random read via dummy write
        set_idx(10'h011, 1);
        rd_begin();
        rd_data(1, "R6 random read byte0");
        rd_data(1, "R6 random read byte1");
        rd_data(0, "R6 random read byte2");
        t_stop(); wt(20);

        // R7: current-address read continues at 0x014
        rd_begin();
        rd_data(0, "R7 current address read");
        t_stop(); wt(20);

        // R5: fixed pointer
        set_idx(10'h200, 0);
        wr_data(8'h11); wr_data(8'h22);
        t_stop(); wt(20);
        chk(regs[10'h201] == (8'h01 ^ 8'h5A), "R5 neighbour untouched", regs[10'h201], 8'h01 ^ 8'h5A);
        rd_begin();
        rd_data(1, "R5 fixed read 1");
        rd_data(0, "R5 fixed read 2");
        t_stop(); wt(20);

        // R3: upper index bits
        set_idx(10'h2FE, 1);
        wr_data(8'h77); wr_data(8'h88);
        t_stop(); wt(20);
        set_idx(10'h2FF, 0);
        rd_begin();
        rd_data(0, "R3 upper index readback");
        t_stop(); wt(20);

        // R8: unavailable register
        base = we_cnt;
        set_idx(10'h3FF, 1);
        wr_data(8'h99);
        t_stop(); wt(20);
        rd_begin();
        t_stop(); wt(20);
        chk(we_cnt == base, "R8 no write to unavailable", we_cnt, base);

        // R2: foreign device address, then a matching byte without START
        base = we_cnt;
        t_start();
        wbyte(8'hA0, a); chk(!a, "R2 foreign address nack", a, 0);
        wbyte(8'hD4, a); chk(!a, "R2 silent until START", a, 0);
        t_stop(); wt(20);
        chk(we_cnt == base, "R2 no register access", we_cnt, base);

        // R9: START in mid-byte aborts it
        t_start();
        send_bit(1); send_bit(1); send_bit(0); send_bit(1);
        chk(sda_oe == 0, "R9 silent during partial byte", sda_oe, 0);
        set_idx(10'h020, 1);
        wr_data(8'h5A);
        t_stop(); wt(20);
        chk(regs[10'h020] == 8'h5A, "R9 write after abort", regs[10'h020], 8'h5A);

        base = 0;
        for (int i = 0; i < 1024; i++) if (regs[i] !== exp_mem[i]) base++;
        chk(base == 0, "R4 R5 bank matches model", base, 0);
        finish_run();
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end
endmodule